// File: doc/BRIEF.md
# OTP Fuse Program Sequencer

This block sits between a simple register bus and a one-time-programmable fuse array. Software writes a word (or bank) address together with a 16-bit unlock key into the control register, then writes the program data. The data write starts a burn sequence. The sequencer first reads the target fuse word. It then issues a program request only for the bits that are still unblown. A reload request copies the whole array into shadow registers, which the bus can then read.

The block protects the array in three ways. A key is consumed by every program attempt. A program to a locked or out-of-range word never reaches the array and raises a sticky error flag. While the sequencer is busy, or while the error flag is set, data writes, program starts and reloads are ignored.

A parameter selects banked operation. In banked mode the address picks a bank of four consecutive words. The burn of all four starts only when data register 0 is written.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset, the control view, the timing register and all data registers read as zero.
- R2: Control register read layout: the address field is in bits [ADDR_W-1:0], busy is in bit ADDR_W, error is in bit ADDR_W+1, reload is in bit ADDR_W+2, and the key is in bits [31:16].
  - A write to offset 0x0 replaces the address and key fields.
  - Offset 0x4 ORs bits into those fields.
  - Offset 0x8 clears those bits.
  - Timing (0x10) is a plain 32-bit read/write register.
  - Data registers k=0..3 sit at 0x20+0x10*k.
- R3: A write to data register 0 while the key field equals 0x3E77 starts a program. Busy reads 1 in the cycle after that write, and the key field reads 0.
- R4: Without the key, a data-register write only stores the value. No fuse request is made and busy stays 0.
- R5: Before each program request the target word is read. The value programmed is the requested data AND NOT the current contents. When that result is zero, no program request is issued.
- R6: The target word is latched at program start. Later address writes do not redirect the burn, and data-register writes while busy are ignored.
- R7: A program to a locked word (lock_map bit set) or to a word beyond the array does not set busy and makes no fuse access. It sets the error flag and clears the key.
- R8: While the error flag is set, data writes and reload requests are ignored. The flag is cleared only by writing a 1 at the error position to the clear alias.
- R9: Setting the reload bit through the set alias while idle raises busy and reload. Every word is copied into a shadow readable at 0x400+0x10*i, and then both flags clear.
- R10: In banked mode, writes to data registers 1 to 3 only store. A write to data register 0 burns words 4*A+k in the order k=0,1,2,3 with data register k. A bank containing any locked word raises the error flag.
- R11: A reload request made while busy is ignored, and busy falls once the last fuse operation is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lock_map | input | NUM_WORDS | Per-word program lock, 1 = locked |
| fuse_req | output | 1 | Fuse access request, held until acknowledged |
| fuse_we | output | 1 | 1 = program, 0 = read |
| fuse_idx | output | $clog2(NUM_WORDS) | Fuse word index |
| fuse_wdata | output | 32 | Bits to blow |
| fuse_ack | input | 1 | One-cycle completion pulse |
| fuse_rdata | input | 32 | Word read, valid with fuse_ack |

## Verification
The bench builds two instances side by side.
- The first uses an 8-bit address field, 16 words and no banking. It exercises the single-word program, masking, locking and reload paths.
- The second uses a 9-bit address field with banking enabled. This moves busy, error and reload up by one bit, so the wide register layout is reached. It also checks the four-word burn order, a locked bank and a bank beyond the array.

Each instance drives a fuse model with an eight-cycle latency. That latency leaves enough busy cycles to land address, data and reload writes in the middle of a burn.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int unsigned OFS_CTRL      = 32'h000;
  localparam int unsigned OFS_CSET      = 32'h004;
  localparam int unsigned OFS_CCLR      = 32'h008;
  localparam int unsigned OFS_TIMING    = 32'h010;
  localparam int unsigned OFS_DATA_BASE = 32'h020;
  localparam int unsigned DATA_STRIDE   = 32'h010;
  localparam int unsigned NUM_DATA      = 4;
  localparam int unsigned OFS_SHADOW    = 32'h400;
  localparam int unsigned SHADOW_STRIDE = 32'h010;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PRD  = 2'd1,
    SQ_PWR  = 2'd2,
    SQ_RLD  = 2'd3
  } seq_state_e;

  // Bits that still need blowing once the current contents are known.
  function automatic logic [31:0] burn_mask(input logic [31:0] want,
                                            input logic [31:0] blown);
    return want & ~blown;
  endfunction

  // Fuse word index for a control address and a data slot.
  function automatic int unsigned fuse_index(input int unsigned sel_addr,
                                             input int unsigned slot,
                                             input bit banked);
    return banked ? (sel_addr * NUM_DATA + slot) : sel_addr;
  endfunction

  // Data register slot for a byte offset, or -1 when the offset is not a data register.
  function automatic int data_slot(input logic [31:0] ofs);
    if (ofs >= OFS_DATA_BASE && ofs < OFS_DATA_BASE + NUM_DATA * DATA_STRIDE &&
        ((ofs - OFS_DATA_BASE) % DATA_STRIDE) == 0)
      return int'((ofs - OFS_DATA_BASE) / DATA_STRIDE);
    return -1;
  endfunction

endpackage

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int BANKED    = 0,
  parameter int BUS_AW    = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_wr,
  input  logic [BUS_AW-1:0]                bus_addr,
  input  logic [31:0]                      bus_wdata,
  input  logic [NUM_WORDS-1:0]             lock_map,
  input  logic                             busy,
  output logic [ADDR_W-1:0]                addr_q,
  output logic [15:0]                      key_q,
  output logic                             err_q,
  output logic [31:0]                      timing_q,
  output logic [NUM_DATA-1:0][31:0]        data_q,
  output logic                             prog_go,
  output logic                             reload_go,
  output logic                             lock_hit,
  output logic [NUM_DATA-1:0][31:0]        go_data
);

  localparam int ERR_BIT = ADDR_W + 1;
  localparam int RLD_BIT = ADDR_W + 2;
  localparam int SPAN    = (BANKED != 0) ? NUM_DATA : 1;
  localparam int IW      = $clog2(NUM_WORDS);

  logic [31:0] ofs;
  int          slot_w;
  logic        wr_ctrl, wr_set, wr_clr, wr_time, wr_data;
  logic        idle_ok, tgt_lock, req_prog;

  assign ofs     = 32'(bus_addr);
  assign slot_w  = data_slot(ofs);
  assign wr_ctrl = bus_wr && (ofs == OFS_CTRL);
  assign wr_set  = bus_wr && (ofs == OFS_CSET);
  assign wr_clr  = bus_wr && (ofs == OFS_CCLR);
  assign wr_time = bus_wr && (ofs == OFS_TIMING);
  assign wr_data = bus_wr && (slot_w >= 0);
  assign idle_ok = !busy && !err_q;

  // Locked or out-of-range target anywhere in the span of the request.
  always_comb begin
    tgt_lock = 1'b0;
    for (int k = 0; k < SPAN; k++) begin
      int unsigned wi;
      wi = fuse_index(32'(addr_q), k, BANKED != 0);
      if (wi >= NUM_WORDS)       tgt_lock = 1'b1;
      else if (lock_map[wi[IW-1:0]]) tgt_lock = 1'b1;
    end
  end

  assign req_prog  = wr_data && (slot_w == 0) && (key_q == UNLOCK_KEY) && idle_ok;
  assign lock_hit  = req_prog && tgt_lock;
  assign prog_go   = req_prog && !tgt_lock;
  assign reload_go = wr_set && bus_wdata[RLD_BIT] && idle_ok;

  always_comb begin
    go_data    = data_q;
    go_data[0] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      key_q    <= '0;
      err_q    <= 1'b0;
      timing_q <= '0;
      data_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        addr_q <= bus_wdata[ADDR_W-1:0];
        key_q  <= bus_wdata[31:16];
      end
      if (wr_set) begin
        addr_q <= addr_q | bus_wdata[ADDR_W-1:0];
        key_q  <= key_q | bus_wdata[31:16];
      end
      if (wr_clr) begin
        addr_q <= addr_q & ~bus_wdata[ADDR_W-1:0];
        key_q  <= key_q & ~bus_wdata[31:16];
        if (bus_wdata[ERR_BIT]) err_q <= 1'b0;
      end
      if (wr_time) timing_q <= bus_wdata;
      if (wr_data && idle_ok) data_q[slot_w[1:0]] <= bus_wdata;
      if (req_prog) key_q <= '0;
      if (lock_hit) err_q <= 1'b1;
    end
  end

  // R3: every program attempt spends the key
  p_key_spent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || lock_hit) |=> (key_q == 16'h0));

  // R8: the error flag only falls through the clear alias
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_clr && bus_wdata[ERR_BIT])) |=> err_q);

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int BANKED    = 0,
  parameter int IW        = $clog2(NUM_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prog_go,
  input  logic                          reload_go,
  input  logic [ADDR_W-1:0]             go_addr,
  input  logic [NUM_DATA-1:0][31:0]     go_data,
  output logic                          busy,
  output logic                          reloading,
  output logic [NUM_WORDS-1:0][31:0]    shadow_q,
  output logic                          fuse_req,
  output logic                          fuse_we,
  output logic [IW-1:0]                 fuse_idx,
  output logic [31:0]                   fuse_wdata,
  input  logic                          fuse_ack,
  input  logic [31:0]                   fuse_rdata
);

  localparam logic [1:0]    LAST_SLOT = (BANKED != 0) ? 2'(NUM_DATA - 1) : 2'd0;
  localparam logic [IW-1:0] LAST_WORD = IW'(NUM_WORDS - 1);

  seq_state_e                  state_q;
  logic [1:0]                  slot_q;
  logic [IW-1:0]               base_q, rl_idx_q, cur_idx;
  logic [NUM_DATA-1:0][31:0]   data_lat;
  logic [31:0]                 burn_q, blown_q, masked;

  // Named internal events
  logic ev_rd_done, ev_skip, ev_wr_done, ev_advance, ev_last;

  assign cur_idx    = base_q + IW'(slot_q);
  assign masked     = burn_mask(data_lat[slot_q], fuse_rdata);
  assign ev_rd_done = (state_q == SQ_PRD) && fuse_ack;
  assign ev_skip    = ev_rd_done && (masked == 32'h0);
  assign ev_wr_done = (state_q == SQ_PWR) && fuse_ack;
  assign ev_advance = ev_skip || ev_wr_done;
  assign ev_last    = (slot_q == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      slot_q   <= '0;
      base_q   <= '0;
      rl_idx_q <= '0;
      data_lat <= '0;
      burn_q   <= '0;
      blown_q  <= '0;
      shadow_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (prog_go) begin
            base_q   <= IW'(fuse_index(32'(go_addr), 0, BANKED != 0));
            data_lat <= go_data;
            slot_q   <= '0;
            state_q  <= SQ_PRD;
          end else if (reload_go) begin
            rl_idx_q <= '0;
            state_q  <= SQ_RLD;
          end
        end
        SQ_PRD: begin
          if (ev_rd_done) begin
            blown_q <= fuse_rdata;
            if (!ev_skip) begin
              burn_q  <= masked;
              state_q <= SQ_PWR;
            end
          end
        end
        SQ_PWR: ;
        SQ_RLD: begin
          if (fuse_ack) begin
            shadow_q[rl_idx_q] <= fuse_rdata;
            if (rl_idx_q == LAST_WORD) state_q <= SQ_IDLE;
            else                       rl_idx_q <= rl_idx_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
      if (ev_advance) begin
        if (ev_last) state_q <= SQ_IDLE;
        else begin
          slot_q  <= slot_q + 1'b1;
          state_q <= SQ_PRD;
        end
      end
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign reloading  = (state_q == SQ_RLD);
  assign fuse_req   = busy;
  assign fuse_we    = (state_q == SQ_PWR);
  assign fuse_idx   = reloading ? rl_idx_q : cur_idx;
  assign fuse_wdata = fuse_we ? burn_q : 32'h0;

  // R5: a program request never touches an already blown bit and is never empty
  p_no_reblow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req && fuse_we) |-> (((fuse_wdata & blown_q) == 32'h0) && (fuse_wdata != 32'h0)));

  // R6: the latched target is held for the whole burn
  p_hold_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !reloading) |-> $stable(base_q));

endmodule

// File: rtl/otp_fuse_model.sv
module otp_fuse_model #(
  parameter int NUM_WORDS = 16,
  parameter int LAT       = 3,
  parameter int IW        = $clog2(NUM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic          ack,
  output logic [31:0]   rdata
);

  localparam int CW = $clog2(LAT + 1);

  logic [NUM_WORDS-1:0][31:0] cells;
  logic [CW-1:0]              cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
      cnt   <= '0;
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (cnt == CW'(LAT - 1)) begin
          cnt   <= '0;
          ack   <= 1'b1;
          rdata <= cells[idx];
          if (we) cells[idx] <= cells[idx] | wdata;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 16,
  parameter int BANKED    = 0,
  parameter int BUS_AW    = 12,
  localparam int IW       = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_WORDS-1:0] lock_map,
  output logic                 fuse_req,
  output logic                 fuse_we,
  output logic [IW-1:0]        fuse_idx,
  output logic [31:0]          fuse_wdata,
  input  logic                 fuse_ack,
  input  logic [31:0]          fuse_rdata
);

  localparam int BUSY_BIT = ADDR_W;
  localparam int ERR_BIT  = ADDR_W + 1;
  localparam int RLD_BIT  = ADDR_W + 2;

  logic [ADDR_W-1:0]            addr_q;
  logic [15:0]                  key_q;
  logic                         err_q, busy, reloading;
  logic [31:0]                  timing_q;
  logic [NUM_DATA-1:0][31:0]    data_q, go_data;
  logic                         prog_go, reload_go, lock_hit;
  logic [NUM_WORDS-1:0][31:0]   shadow_q;

  otp_regs #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .BANKED(BANKED), .BUS_AW(BUS_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .lock_map(lock_map), .busy(busy),
    .addr_q(addr_q), .key_q(key_q), .err_q(err_q), .timing_q(timing_q),
    .data_q(data_q), .prog_go(prog_go), .reload_go(reload_go),
    .lock_hit(lock_hit), .go_data(go_data)
  );

  otp_seq #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .BANKED(BANKED), .IW(IW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .reload_go(reload_go),
    .go_addr(addr_q), .go_data(go_data), .busy(busy), .reloading(reloading),
    .shadow_q(shadow_q), .fuse_req(fuse_req), .fuse_we(fuse_we),
    .fuse_idx(fuse_idx), .fuse_wdata(fuse_wdata), .fuse_ack(fuse_ack),
    .fuse_rdata(fuse_rdata)
  );

  logic [31:0] ctrl_view;
  always_comb begin
    ctrl_view                 = '0;
    ctrl_view[ADDR_W-1:0]     = addr_q;
    ctrl_view[BUSY_BIT]       = busy;
    ctrl_view[ERR_BIT]        = err_q;
    ctrl_view[RLD_BIT]        = reloading;
    ctrl_view[31:16]          = key_q;
  end

  always_comb begin
    logic [31:0] ofs;
    int          slot;
    int unsigned si;
    ofs       = 32'(bus_addr);
    slot      = data_slot(ofs);
    si        = (ofs - OFS_SHADOW) / SHADOW_STRIDE;
    bus_rdata = '0;
    if (ofs == OFS_CTRL || ofs == OFS_CSET || ofs == OFS_CCLR)
      bus_rdata = ctrl_view;
    else if (ofs == OFS_TIMING)
      bus_rdata = timing_q;
    else if (slot >= 0)
      bus_rdata = data_q[slot[1:0]];
    else if (ofs >= OFS_SHADOW && ((ofs - OFS_SHADOW) % SHADOW_STRIDE) == 0 &&
             si < NUM_WORDS)
      bus_rdata = shadow_q[si[IW-1:0]];
  end

  // R3: busy only rises on an accepted start
  p_busy_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go || reload_go));

  // R7: a locked target leaves the array idle and raises the error flag
  p_lock_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> (!fuse_req && err_q));

  // R9: an accepted reload shows both flags on the next cycle
  p_reload_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go |=> (reloading && busy));

endmodule

// File: tb/otp_prog_ctrl_bench.sv
module otp_prog_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  // Instance A: 8-bit address field, single word per program
  logic        fa_req, fa_we, fa_ack;
  logic [3:0]  fa_idx;
  logic [31:0] fa_wdata, fa_rdata;

  otp_prog_ctrl #(.ADDR_W(8), .NUM_WORDS(16), .BANKED(0), .BUS_AW(12)) u_otp_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && !sel), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_a), .lock_map(16'h0020), .fuse_req(fa_req), .fuse_we(fa_we),
    .fuse_idx(fa_idx), .fuse_wdata(fa_wdata), .fuse_ack(fa_ack), .fuse_rdata(fa_rdata)
  );
  otp_fuse_model #(.NUM_WORDS(16), .LAT(8)) u_fa (
    .clk(clk), .rst_n(rst_n), .req(fa_req), .we(fa_we), .idx(fa_idx),
    .wdata(fa_wdata), .ack(fa_ack), .rdata(fa_rdata)
  );

  // Instance B: 9-bit address field, banked
  logic        fb_req, fb_we, fb_ack;
  logic [3:0]  fb_idx;
  logic [31:0] fb_wdata, fb_rdata;

  otp_prog_ctrl #(.ADDR_W(9), .NUM_WORDS(16), .BANKED(1), .BUS_AW(12)) u_otp_prog_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_b), .lock_map(16'h0200), .fuse_req(fb_req), .fuse_we(fb_we),
    .fuse_idx(fb_idx), .fuse_wdata(fb_wdata), .fuse_ack(fb_ack), .fuse_rdata(fb_rdata)
  );
  otp_fuse_model #(.NUM_WORDS(16), .LAT(8)) u_fb (
    .clk(clk), .rst_n(rst_n), .req(fb_req), .we(fb_we), .idx(fb_idx),
    .wdata(fb_wdata), .ack(fb_ack), .rdata(fb_rdata)
  );

  // Fuse program monitors
  int          wa_cnt = 0;
  logic [3:0]  wa_idx;
  logic [31:0] wa_dat;
  int          wb_cnt = 0;
  logic [3:0]  wb_idx [0:7];
  logic [31:0] wb_dat [0:7];

  always @(posedge clk) begin
    if (fa_req && fa_we && fa_ack) begin
      wa_cnt = wa_cnt + 1;
      wa_idx = fa_idx;
      wa_dat = fa_wdata;
    end
    if (fb_req && fb_we && fb_ack) begin
      if (wb_cnt < 8) begin
        wb_idx[wb_cnt] = fb_idx;
        wb_dat[wb_cnt] = fb_wdata;
      end
      wb_cnt = wb_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic s, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bread(input logic s, input logic [11:0] a, output logic [31:0] d);
    sel = s; addr = a;
    #1;
    d = s ? rdata_b : rdata_a;
  endtask

  task automatic wait_idle(input logic s, input int busy_bit);
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      bread(s, 12'h000, v);
      if (!v[busy_bit]) done = 1;
      else @(negedge clk);
    end
    if (!done) check("R11 busy timeout", 32'h1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bread(0, 12'h000, v); check("R1 ctrl A", v, 32'h0);
    bread(0, 12'h010, v); check("R1 timing A", v, 32'h0);
    bread(0, 12'h020, v); check("R1 data0 A", v, 32'h0);
    bread(1, 12'h000, v); check("R1 ctrl B", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    bwrite(0, 12'h000, 32'h0000_00A5); bread(0, 12'h000, v); check("R2 ctrl write", v, 32'h0000_00A5);
    bwrite(0, 12'h004, 32'h0000_0003); bread(0, 12'h000, v); check("R2 set alias", v, 32'h0000_00A7);
    bwrite(0, 12'h008, 32'h0000_0021); bread(0, 12'h000, v); check("R2 clr alias", v, 32'h0000_0086);
    bwrite(0, 12'h000, 32'h1234_0000); bread(0, 12'h000, v); check("R2 key field", v, 32'h1234_0000);
    bwrite(0, 12'h010, 32'hDEAD_BEEF); bread(0, 12'h010, v); check("R2 timing", v, 32'hDEAD_BEEF);
    bwrite(0, 12'h040, 32'h0BAD_F00D); bread(0, 12'h040, v); check("R2 data2", v, 32'h0BAD_F00D);
    bwrite(1, 12'h000, 32'h0000_01FF); bread(1, 12'h000, v); check("R2 wide addr", v, 32'h0000_01FF);
    bwrite(1, 12'h000, 32'h0);
  endtask

  task automatic t_nounlock();
    logic [31:0] v;
    bwrite(0, 12'h000, 32'h0000_0003);
    bwrite(0, 12'h020, 32'h0000_000F);
    bread(0, 12'h000, v); check("R4 no busy", v, 32'h0000_0003);
    repeat (30) @(negedge clk);
    check("R4 no fuse write", 32'(wa_cnt), 32'd0);
    bread(0, 12'h020, v); check("R4 data stored", v, 32'h0000_000F);
  endtask

  task automatic t_prog();
    logic [31:0] v;
    bwrite(0, 12'h000, 32'h3E77_0003);
    bwrite(0, 12'h020, 32'h0000_00F0);
    bread(0, 12'h000, v); check("R3 busy and key spent", v, 32'h0000_0103);
    wait_idle(0, 8);
    bread(0, 12'h000, v); check("R11 busy cleared", v, 32'h0000_0003);
    check("R3 one write", 32'(wa_cnt), 32'd1);
    check("R3 write index", 32'(wa_idx), 32'd3);
    check("R3 write data", wa_dat, 32'h0000_00F0);
  endtask

  task automatic t_mask();
    bwrite(0, 12'h000, 32'h3E77_0003);
    bwrite(0, 12'h020, 32'h0000_0FF0);
    wait_idle(0, 8);
    check("R5 masked count", 32'(wa_cnt), 32'd2);
    check("R5 masked data", wa_dat, 32'h0000_0F00);
    bwrite(0, 12'h000, 32'h3E77_0003);
    bwrite(0, 12'h020, 32'h0000_0030);
    wait_idle(0, 8);
    check("R5 no write when all blown", 32'(wa_cnt), 32'd2);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    bwrite(0, 12'h000, 32'h3E77_0007);
    bwrite(0, 12'h020, 32'h0000_0001);
    bwrite(0, 12'h000, 32'h0000_0002);
    bwrite(0, 12'h020, 32'h0000_0055);
    bwrite(0, 12'h004, 32'h0000_0400);
    bread(0, 12'h000, v); check("R11 reload ignored while busy", v, 32'h0000_0102);
    wait_idle(0, 8);
    bread(0, 12'h000, v); check("R11 no late reload", v, 32'h0000_0002);
    check("R6 latched index", 32'(wa_idx), 32'd7);
    check("R6 latched data", wa_dat, 32'h0000_0001);
    bread(0, 12'h020, v); check("R6 busy data write ignored", v, 32'h0000_0001);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    bwrite(0, 12'h000, 32'h3E77_0005);
    bwrite(0, 12'h020, 32'h0000_00FF);
    bread(0, 12'h000, v); check("R7 error no busy key spent", v, 32'h0000_0205);
    repeat (20) @(negedge clk);
    check("R7 no fuse access", 32'(wa_cnt), 32'd3);
    bwrite(0, 12'h000, 32'h3E77_0004);
    bwrite(0, 12'h020, 32'h0000_0001);
    bread(0, 12'h000, v); check("R8 program ignored under error", v, 32'h3E77_0204);
    bread(0, 12'h020, v); check("R8 data unchanged under error", v, 32'h0000_00FF);
    bwrite(0, 12'h004, 32'h0000_0400);
    bread(0, 12'h000, v); check("R8 reload ignored under error", v, 32'h3E77_0204);
    bwrite(0, 12'h008, 32'h0000_0200);
    bread(0, 12'h000, v); check("R8 error cleared", v, 32'h3E77_0004);
    bwrite(0, 12'h020, 32'h0000_0001);
    wait_idle(0, 8);
    check("R8 program after clear", 32'(wa_idx), 32'd4);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    bwrite(0, 12'h004, 32'h0000_0400);
    bread(0, 12'h000, v); check("R9 reload flags", v, 32'h0000_0504);
    wait_idle(0, 8);
    bread(0, 12'h000, v); check("R9 flags cleared", v, 32'h0000_0004);
    bread(0, 12'h430, v); check("R9 shadow word3", v, 32'h0000_0FF0);
    bread(0, 12'h470, v); check("R9 shadow word7", v, 32'h0000_0001);
    bread(0, 12'h440, v); check("R9 shadow word4", v, 32'h0000_0001);
    bread(0, 12'h450, v); check("R9 shadow locked word5", v, 32'h0);
    bread(0, 12'h400, v); check("R9 shadow word0", v, 32'h0);
  endtask

  task automatic t_bank();
    logic [31:0] v;
    bwrite(1, 12'h030, 32'h0000_0011);
    bwrite(1, 12'h040, 32'h0000_0022);
    bwrite(1, 12'h050, 32'h0000_0033);
    bread(1, 12'h000, v); check("R10 staging no busy", v, 32'h0);
    check("R10 staging no fuse", 32'(wb_cnt), 32'd0);
    bwrite(1, 12'h000, 32'h3E77_0001);
    bwrite(1, 12'h020, 32'h0000_0010);
    bread(1, 12'h000, v); check("R10 wide busy bit", v, 32'h0000_0201);
    wait_idle(1, 9);
    check("R10 four writes", 32'(wb_cnt), 32'd4);
    for (int k = 0; k < 4; k++) begin
      check("R10 order index", 32'(wb_idx[k]), 32'(4 + k));
    end
    check("R10 slot0 data", wb_dat[0], 32'h10);
    check("R10 slot1 data", wb_dat[1], 32'h11);
    check("R10 slot2 data", wb_dat[2], 32'h22);
    check("R10 slot3 data", wb_dat[3], 32'h33);
    bwrite(1, 12'h000, 32'h3E77_0002);
    bwrite(1, 12'h020, 32'h0000_0005);
    bread(1, 12'h000, v); check("R10 locked bank error", v, 32'h0000_0402);
    bwrite(1, 12'h008, 32'h0000_0400);
    bwrite(1, 12'h000, 32'h3E77_0004);
    bwrite(1, 12'h020, 32'h0000_0005);
    bread(1, 12'h000, v); check("R7 bank beyond array", v, 32'h0000_0404);
    repeat (20) @(negedge clk);
    check("R7 banked no access", 32'(wb_cnt), 32'd4);
    bwrite(1, 12'h008, 32'h0000_0400);
    bwrite(1, 12'h004, 32'h0000_0800);
    wait_idle(1, 9);
    bread(1, 12'h450, v); check("R9 banked shadow word5", v, 32'h0000_0011);
    bread(1, 12'h470, v); check("R9 banked shadow word7", v, 32'h0000_0033);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_nounlock();
    t_prog();
    t_mask();
    t_latch();
    t_lock();
    t_reload();
    t_bank();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule